// File: doc/BRIEF.md
# Switch-Gated RGB LED Dimmer

This block sets the brightness of a row of RGB LEDs with pulse-width modulation. It keeps one brightness level for each colour (blue, green, red), and every LED uses these three shared levels. Each LED also has its own enable switch. An LED whose switch is off stays dark. An LED whose switch is on shows the shared colour mix.

Three push buttons step the levels. One button is assigned to each colour. The block synchronises each raw button input and then detects its rising edge, so one press adds one step no matter how long the button is held. A level wraps to zero when it steps past its maximum. A press only takes effect while at least one LED is enabled. A free-running counter produces the PWM waveform. Each output is high while the counter is below the colour's level scaled up to the counter width.

Top module: `rgb_dimmer`

## Requirements
- R1: While reset is asserted, and on every cycle after it until a switch is enabled, all outputs are low. Reset also clears all three colour levels to 0.
- R2: Output bits `led_o[3*i+2 : 3*i]` of LED i stay low whenever the synchronised switch `sw_i[i]` is off.
- R3: Button `btn_i[0]` steps the blue level, `btn_i[1]` steps green and `btn_i[2]` steps red. Colour c of LED i drives output bit `led_o[3*i+c]` (c = 0 blue, 1 green, 2 red).
- R4: A press adds exactly one step to its level, however many cycles the button is held high.
- R5: A press made while every synchronised switch is off leaves all levels unchanged.
- R6: A level is LEVEL_W bits wide. A press at the maximum value (15 by default) wraps the level to 0.
- R7: Over any 2**PWM_W consecutive cycles with stable inputs, an enabled output is high for exactly level * 2**(PWM_W-LEVEL_W) cycles. A level of 0 keeps the output low.
- R8: The levels are shared, so every enabled LED drives the same waveform on a given colour in the same cycle.
- R9: Latency is fixed. A switch change sampled on a rising edge appears at the outputs after the third rising edge. A button edge changes the level on the third rising edge after sampling, and the outputs on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_i | input | NUM_LEDS | Per-LED enable switches, asynchronous |
| btn_i | input | 3 | Step buttons: bit 0 blue, bit 1 green, bit 2 red, asynchronous |
| led_o | output | 3*NUM_LEDS | PWM outputs; bit 3*i+c is colour c of LED i |

## Verification
The bench builds the block with four LEDs, 4-bit levels and a 6-bit PWM counter. This gives a 64-cycle period in which every level maps to a multiple of four high cycles. Whole-period duty counts are therefore short enough to repeat after each press. The same settings make it quick to reach the wrap from 15 back to 0. A cycle-accurate model running beside the design checks the three-edge switch latency and the four-edge button latency on every clock.

// File: rtl/rgb_dimmer_pkg.sv
package rgb_dimmer_pkg;
    // Number of colour channels per LED and their bit order inside an LED group.
    localparam int unsigned NUM_COLORS = 3;

    typedef enum logic [1:0] {
        COL_BLUE  = 2'd0,
        COL_GREEN = 2'd1,
        COL_RED   = 2'd2
    } color_e;
endpackage

// File: rtl/dim_sync.sv
// Two-flop synchroniser for a bus of independent asynchronous inputs.
module dim_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/dim_levels.sv
// Per-colour level counters stepped on a rising button edge while any LED is enabled.
module dim_levels
    import rgb_dimmer_pkg::*;
#(
    parameter int unsigned LEVEL_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_COLORS-1:0]         btn_s_i,
    input  logic                          any_en_i,
    output logic [NUM_COLORS*LEVEL_W-1:0] level_o
);
    typedef struct packed {
        logic [NUM_COLORS-1:0]              prev;
        logic [NUM_COLORS-1:0][LEVEL_W-1:0] lvl;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = btn_s_i;
        for (int c = 0; c < int'(NUM_COLORS); c++) begin
            if (btn_s_i[c] && !st_q.prev[c] && any_en_i) begin
                st_d.lvl[c] = st_q.lvl[c] + 1'b1;   // natural wrap at 2**LEVEL_W
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;
endmodule

// File: rtl/dim_pwm.sv
// Free-running counter compared against scaled levels; outputs gated per LED.
module dim_pwm
    import rgb_dimmer_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 4,
    parameter int unsigned LEVEL_W  = 4,
    parameter int unsigned PWM_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LEDS-1:0]            en_i,
    input  logic [NUM_COLORS*LEVEL_W-1:0]  level_i,
    output logic [NUM_LEDS*NUM_COLORS-1:0] pwm_o
);
    localparam int unsigned SHIFT = PWM_W - LEVEL_W;
    localparam int unsigned NOUT  = NUM_LEDS * NUM_COLORS;

    typedef struct packed {
        logic [PWM_W-1:0] cnt;
        logic [NOUT-1:0]  out;
    } pwm_t;

    pwm_t st_d, st_q;
    logic [NUM_COLORS-1:0][PWM_W-1:0] thresh;
    logic [NUM_COLORS-1:0]            below;

    genvar gc;
    generate
        for (gc = 0; gc < int'(NUM_COLORS); gc++) begin : g_thr
            assign thresh[gc] = PWM_W'(level_i[gc*LEVEL_W +: LEVEL_W]) << SHIFT;
            assign below[gc]  = st_q.cnt < thresh[gc];
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        for (int i = 0; i < int'(NUM_LEDS); i++) begin
            for (int c = 0; c < int'(NUM_COLORS); c++) begin
                st_d.out[i*NUM_COLORS + c] = en_i[i] && below[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.out;
endmodule

// File: rtl/rgb_dimmer.sv
// Top: synchronisers, shared level bank and gated PWM stage.
module rgb_dimmer
    import rgb_dimmer_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 4,
    parameter int unsigned LEVEL_W  = 4,
    parameter int unsigned PWM_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LEDS-1:0]            sw_i,
    input  logic [NUM_COLORS-1:0]          btn_i,
    output logic [NUM_LEDS*NUM_COLORS-1:0] led_o
);
    logic [NUM_LEDS-1:0]           sw_sync;
    logic [NUM_COLORS-1:0]         btn_sync;
    logic [NUM_COLORS*LEVEL_W-1:0] level_bus;

    dim_sync #(.WIDTH(NUM_LEDS)) u_sw_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sw_i),
        .sync_o  (sw_sync)
    );

    dim_sync #(.WIDTH(NUM_COLORS)) u_btn_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (btn_i),
        .sync_o  (btn_sync)
    );

    dim_levels #(.LEVEL_W(LEVEL_W)) u_levels (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_s_i  (btn_sync),
        .any_en_i (|sw_sync),
        .level_o  (level_bus)
    );

    dim_pwm #(
        .NUM_LEDS (NUM_LEDS),
        .LEVEL_W  (LEVEL_W),
        .PWM_W    (PWM_W)
    ) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (sw_sync),
        .level_i (level_bus),
        .pwm_o   (led_o)
    );
endmodule

// File: rtl/rgb_dimmer_chk.sv
module rgb_dimmer_chk #(
    parameter int unsigned NUM_LEDS = 4,
    parameter int unsigned LEVEL_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_LEDS-1:0]     sw_i,
    input logic [NUM_LEDS*3-1:0]   led_o,
    input logic [NUM_LEDS-1:0]     sw_sync,
    input logic [3*LEVEL_W-1:0]    level_bus
);
    // Edges seen since reset release, saturating at 3.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_dark_r1: assert (led_o == '0);
        end
    end

    // R5: no enabled LED means no level change.
    p_dark_press_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sync == '0) |=> $stable(level_bus));

    genvar gc, gi;
    generate
        for (gc = 0; gc < 3; gc++) begin : g_col
            // R4/R6: a level only ever moves by one step, wrapping.
            p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q != 2'd0) &&
                (level_bus[gc*LEVEL_W +: LEVEL_W] != $past(level_bus[gc*LEVEL_W +: LEVEL_W]))
                |-> (level_bus[gc*LEVEL_W +: LEVEL_W] ==
                     LEVEL_W'($past(level_bus[gc*LEVEL_W +: LEVEL_W]) + 1)));
            for (gi = 0; gi < NUM_LEDS; gi++) begin : g_led
                // R7: a zero level never lights the output.
                p_zero_level_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    (age_q >= 2'd2) && ($past(level_bus[gc*LEVEL_W +: LEVEL_W]) == '0)
                    |-> !led_o[gi*3 + gc]);
            end
        end
        for (gi = 0; gi < NUM_LEDS; gi++) begin : g_gate
            // R2: switch off three edges ago means dark now.
            p_switch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd3) && !$past(sw_i[gi], 3) |-> (led_o[gi*3 +: 3] == 3'b000));
            if (gi > 0) begin : g_share
                // R8: enabled LEDs share one waveform per colour.
                p_shared_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    (age_q >= 2'd2) && $past(sw_sync[0]) && $past(sw_sync[gi])
                    |-> (led_o[gi*3 +: 3] == led_o[2:0]));
            end
        end
    endgenerate
endmodule

bind rgb_dimmer rgb_dimmer_chk #(
    .NUM_LEDS (NUM_LEDS),
    .LEVEL_W  (LEVEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_i      (sw_i),
    .led_o     (led_o),
    .sw_sync   (sw_sync),
    .level_bus (level_bus)
);

// File: tb/rgb_dimmer_bench.sv
module rgb_dimmer_bench;
    localparam int NL     = 4;
    localparam int LW     = 4;
    localparam int PW     = 6;
    localparam int PERIOD = 1 << PW;
    localparam int SCALE  = 1 << (PW - LW);
    localparam int LEVELS = 1 << LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] sw = '0;
    logic [2:0]    btn = '0;
    logic [NL*3-1:0] led;

    int checks = 0;
    int fails  = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rgb_dimmer #(.NUM_LEDS(NL), .LEVEL_W(LW), .PWM_W(PW)) u_rgb_dimmer (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_i  (sw),
        .btn_i (btn),
        .led_o (led)
    );

    // Behavioural reference: input history queues, integer levels and phase.
    logic [2:0]    h_b1, h_b2, h_b3;
    logic [NL-1:0] h_w1, h_w2;
    int            m_lvl [3];
    int            m_phase;
    logic [NL*3-1:0] m_led;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_b1 = '0; h_b2 = '0; h_b3 = '0; h_w1 = '0; h_w2 = '0;
            for (int c = 0; c < 3; c++) m_lvl[c] = 0;
            m_phase = 0; m_led = '0;
        end else begin
            for (int i = 0; i < NL; i++)
                for (int c = 0; c < 3; c++)
                    m_led[i*3+c] = h_w2[i] && (m_phase < m_lvl[c] * SCALE);
            for (int c = 0; c < 3; c++)
                if (h_b2[c] && !h_b3[c] && (h_w2 != '0)) m_lvl[c] = (m_lvl[c] + 1) % LEVELS;
            m_phase = (m_phase + 1) % PERIOD;
            h_b3 = h_b2; h_b2 = h_b1; h_b1 = btn;
            h_w2 = h_w1; h_w1 = sw;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R9 and overall timing: compare against the model on every cycle.
    always @(negedge clk) begin
        if (rst_n && model_on)
            check(led == m_led, "R9 cycle model", int'(led), int'(m_led));
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int c, input int hold);
        @(negedge clk);
        btn[c] = 1'b1;
        wait_cyc(hold);
        btn[c] = 1'b0;
        wait_cyc(4);
    endtask

    task automatic duty(input int led_idx, input int c, input int exp, input string tag);
        int hi = 0;
        for (int k = 0; k < PERIOD; k++) begin
            @(negedge clk);
            if (led[led_idx*3+c]) hi++;
        end
        check(hi == exp, tag, hi, exp);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: dark during reset
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(led == '0, "R1 dark in reset", int'(led), 0);
        end
        rst_n = 1'b1;
        model_on = 1'b1;
        wait_cyc(3);
        check(led == '0, "R1 dark after reset", int'(led), 0);

        // R5: press with all switches off is ignored
        press(0, 3);
        sw = 4'b0001;
        wait_cyc(6);
        duty(0, 0, 0, "R5 blue after dark press");

        // R4: long hold gives a single step; R7 duty of level 1
        press(0, 12);
        wait_cyc(4);
        duty(0, 0, 1 * SCALE, "R4 one step for long hold");
        duty(1, 0, 0, "R2 disabled LED stays dark");

        // R3: colour mapping to buttons and bit positions
        for (int k = 0; k < 3; k++) press(1, 2);
        for (int k = 0; k < 15; k++) press(2, 2);
        wait_cyc(4);
        duty(0, 1, 3 * SCALE, "R3 green on bit 1");
        duty(0, 2, 15 * SCALE, "R7 red at maximum");
        duty(0, 0, 1 * SCALE, "R3 blue on bit 0");

        // R8: shared levels on all LEDs
        sw = 4'b1111;
        wait_cyc(5);
        duty(3, 2, 15 * SCALE, "R8 LED3 red shared");
        duty(2, 1, 3 * SCALE, "R8 LED2 green shared");

        // R6: wrap past maximum
        press(2, 2);
        wait_cyc(4);
        duty(3, 2, 0, "R6 red wraps to 0");
        duty(1, 0, 1 * SCALE, "R6 blue unaffected");

        // R2: turning one switch off darkens it
        sw = 4'b1011;
        wait_cyc(5);
        duty(2, 0, 0, "R2 LED2 off");
        duty(2, 1, 0, "R2 LED2 green off");

        // R1: reset clears levels
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        check(led == '0, "R1 dark in second reset", int'(led), 0);
        rst_n = 1'b1;
        sw = 4'b1111;
        wait_cyc(6);
        duty(0, 0, 0, "R1 blue cleared");
        duty(1, 1, 0, "R1 green cleared");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule